// File: doc/BRIEF.md
# Multi-Source Initial Reset Sequencer

This block produces the internal initial reset of a small microcontroller and the single-cycle strobe that lets its CPU begin. It runs on the low-speed oscillator clock and has three sources. The first is an active-low external reset pin. The second is a detector that fires when every pin in a selectable group of input-port pins is low at the same time. The third is a filtered result from a supply-voltage comparator. The internal reset stays high while any source holds it. After the last source lets go, a fixed stabilization wait runs. When the voltage source is enabled by strap, an extra first-sampling wait is added to it. Once the wait completes, the CPU start strobe fires and the internal reset drops in the same cycle.

The port-group source behaves in two ways. In sleep it is immediate: the reset follows the low condition and holds for as long as it lasts. When the CPU is awake, the low condition must be seen on two successive edges of a free-running one-second tick. Once qualified, it produces a self-ending 64-cycle pulse. The CPU then restarts even if the pins stay low, and the detector re-arms only after a selected pin has gone high again. The voltage source applies hysteresis: four strobed samples in a row below level 0 assert reset, and only a sample at level 2 or higher releases it.

Top module: `init_reset_seq`

## Requirements
- R1: While `rst_pin_n` is low, `init_rst` is high (asserted without waiting for a clock edge) and `cpu_start` is low.
- R2: With `svd_enable` low and no other source active, `cpu_start` is high for exactly one cycle. That cycle follows the 8195th rising clock edge after `rst_pin_n` goes high: 2 synchronizer edges, 1 decision edge and OSC_WAIT = 8192 wait edges. `init_rst` falls on the same edge and stays low afterwards.
- R3: With `svd_enable` high, the wait is OSC_WAIT + SVD_WAIT = 8440 edges.
- R4: With `svd_enable` high, reset is not released after power-up until a strobed sample reads code 2 or 3 (at or above level 2). Samples with code 1 (between level 0 and level 2) keep it held. `cpu_start` follows 4 + 8440 edges after the releasing strobe is presented.
- R5: After start-up, four strobed samples in a row with code 0 (below level 0) assert `init_rst`. Any sample with a non-zero code restarts that count.
- R6: A reset caused by the voltage filter is not released by code 1 samples. A code 2 or 3 sample releases it, with the timing of R4.
- R7: The port-group condition needs `port_mask` to be non-zero and every pin selected by the mask to be low. Pins outside the mask are ignored.
- R8: With `sleep_mode` high, `init_rst` rises 3 edges after the condition appears and holds while it lasts. `cpu_start` follows 3 + OSC_WAIT edges after a selected pin goes high. A voltage-filter hold that overlaps keeps reset asserted until it also clears.
- R9: With `sleep_mode` low, `init_rst` rises between TICK_DIV + 4 and 2·TICK_DIV + 3 edges after the condition appears. TICK_DIV is the tick period in clock cycles, 32768 by default (one second).
- R10: That awake-mode reset is a 64-cycle pulse. `cpu_start` follows 64 + OSC_WAIT edges after `init_rst` rises, even if the pins stay low.
- R11: After the awake-mode pulse, a persisting condition does not trigger again. Once a selected pin has returned high, a new condition does trigger again.
- R12: `init_rst` never falls except in the cycle in which `cpu_start` is high, and `cpu_start` never lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Low-speed oscillator clock |
| rst_pin_n | input | 1 | External reset pin, active low |
| port_pins | input | NPIN | Raw input-port pin levels |
| port_mask | input | NPIN | Selects which pins form the simultaneous-low group |
| sleep_mode | input | 1 | High while the CPU is sleeping |
| svd_enable | input | 1 | Strap enabling the voltage-detector reset source |
| svd_code | input | 2 | Comparator result: 0 below level 0, 1 between, 2 or 3 at or above level 2 |
| svd_strobe | input | 1 | Marks a valid comparator sample |
| init_rst | output | 1 | Internal initial reset, active high |
| cpu_start | output | 1 | One-cycle strobe releasing the CPU |

## Verification
Two holds can overlap. A sleep-mode port-group hold and a voltage-filter fault can be active at once, and the sequencer must wait for both to clear before it starts counting. The bench provokes this by pulling the selected pins low in sleep and then delivering four below-level-0 samples. It then raises the pins while the voltage fault remains. It judges the result by seeing that `init_rst` stays high and no start appears, and that the start arrives at the exact expected cycle only after a level-2 sample.

// File: rtl/init_reset_seq_pkg.sv
package init_reset_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_HOLD = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_t;

  localparam logic [1:0] LVL_BELOW0 = 2'd0;
  localparam logic [1:0] LVL_OK     = 2'd2;
endpackage

// File: rtl/init_reset_seq_sync.sv
module init_reset_seq_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/init_reset_seq_svd.sv
module init_reset_seq_svd
  import init_reset_seq_pkg::*;
#(
  parameter int DROP_RUN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       strobe,
  input  logic [1:0] code,
  output logic       fault
);
  localparam int CW = $clog2(DROP_RUN + 1);
  localparam logic [CW-1:0] RUN_FULL = CW'(DROP_RUN);
  localparam logic [CW-1:0] RUN_LAST = CW'(DROP_RUN - 1);

  logic [CW-1:0] run_q, run_d;
  logic          bad_q, bad_d;

  // Hysteresis: consecutive low samples set, a level-2 sample clears.
  always_comb begin
    run_d = run_q;
    bad_d = bad_q;
    if (strobe) begin
      if (code == LVL_BELOW0) begin
        if (run_q != RUN_FULL) run_d = run_q + 1'b1;
        if (run_q == RUN_LAST) bad_d = 1'b1;
      end else begin
        run_d = '0;
        if (code >= LVL_OK) bad_d = 1'b0;
      end
    end
  end

  // bad_q starts set so the first good sample is required at power-up.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      bad_q <= 1'b1;
    end else if (strobe) begin
      run_q <= run_d;
      bad_q <= bad_d;
    end
  end

  assign fault = enable & bad_q;
endmodule

// File: rtl/init_reset_seq_port.sv
module init_reset_seq_port #(
  parameter int NPIN      = 4,
  parameter int TICK_DIV  = 32768,
  parameter int PULSE_LEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pins,
  input  logic [NPIN-1:0] mask,
  input  logic            sleep,
  output logic            hold
);
  localparam int TW = $clog2(TICK_DIV);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_DIV - 1);
  localparam logic [PW-1:0] PULSE_INIT = PW'(PULSE_LEN);

  logic [TW-1:0] div_q, div_d;
  logic [PW-1:0] pulse_q, pulse_d;
  logic          seen_q, seen_d, armed_q, armed_d;
  logic          tick, combo_low;

  assign combo_low = (mask != '0) && ((pins & mask) == '0);
  assign tick      = (div_q == TICK_LAST);

  always_comb begin
    div_d   = tick ? '0 : div_q + 1'b1;
    pulse_d = (pulse_q != '0) ? pulse_q - 1'b1 : pulse_q;
    seen_d  = seen_q;
    armed_d = armed_q;
    if (!combo_low) begin
      seen_d  = 1'b0;
      armed_d = 1'b1;
    end else if (tick && armed_q && !sleep) begin
      if (seen_q) begin
        pulse_d = PULSE_INIT;
        armed_d = 1'b0;
        seen_d  = 1'b0;
      end else begin
        seen_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      pulse_q <= '0;
      seen_q  <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      div_q   <= div_d;
      pulse_q <= pulse_d;
      seen_q  <= seen_d;
      armed_q <= armed_d;
    end
  end

  assign hold = (pulse_q != '0) | (sleep & combo_low);
endmodule

// File: rtl/init_reset_seq.sv
module init_reset_seq
  import init_reset_seq_pkg::*;
#(
  parameter int NPIN      = 4,
  parameter int OSC_WAIT  = 8192,
  parameter int SVD_WAIT  = 248,
  parameter int DROP_RUN  = 4,
  parameter int TICK_DIV  = 32768,
  parameter int PULSE_LEN = 64
) (
  input  logic            clk_osc,
  input  logic            rst_pin_n,
  input  logic [NPIN-1:0] port_pins,
  input  logic [NPIN-1:0] port_mask,
  input  logic            sleep_mode,
  input  logic            svd_enable,
  input  logic [1:0]      svd_code,
  input  logic            svd_strobe,
  output logic            init_rst,
  output logic            cpu_start
);
  localparam int CW = $clog2(OSC_WAIT + SVD_WAIT + 1);
  localparam logic [CW-1:0] LAST_BASE = CW'(OSC_WAIT - 1);
  localparam logic [CW-1:0] LAST_SVD  = CW'(OSC_WAIT + SVD_WAIT - 1);

  logic            rst_n_sync;
  logic [NPIN-1:0] pins_s;
  logic [2:0]      svd_s;
  logic            svd_fault, port_hold, hold;
  seq_state_t      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d, wait_last;
  logic            start_q, start_d;

  // Reset pin: asserts at once, released after two clock edges.
  init_reset_seq_sync #(.W(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk_osc), .rst_n(rst_pin_n), .d(1'b1), .q(rst_n_sync));

  init_reset_seq_sync #(.W(NPIN), .RST_VAL({NPIN{1'b1}})) u_pin_sync (
    .clk(clk_osc), .rst_n(rst_n_sync), .d(port_pins), .q(pins_s));

  init_reset_seq_sync #(.W(3), .RST_VAL(3'b000)) u_svd_sync (
    .clk(clk_osc), .rst_n(rst_n_sync), .d({svd_strobe, svd_code}), .q(svd_s));

  init_reset_seq_svd #(.DROP_RUN(DROP_RUN)) u_svd (
    .clk(clk_osc), .rst_n(rst_n_sync), .enable(svd_enable),
    .strobe(svd_s[2]), .code(svd_s[1:0]), .fault(svd_fault));

  init_reset_seq_port #(.NPIN(NPIN), .TICK_DIV(TICK_DIV), .PULSE_LEN(PULSE_LEN)) u_port (
    .clk(clk_osc), .rst_n(rst_n_sync), .pins(pins_s), .mask(port_mask),
    .sleep(sleep_mode), .hold(port_hold));

  assign hold      = svd_fault | port_hold;
  assign wait_last = svd_enable ? LAST_SVD : LAST_BASE;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    start_d = 1'b0;
    case (state_q)
      SEQ_HOLD: if (!hold) begin
        state_d = SEQ_WAIT;
        cnt_d   = '0;
      end
      SEQ_WAIT: begin
        if (hold) begin
          state_d = SEQ_HOLD;
        end else if (cnt_q == wait_last) begin
          state_d = SEQ_RUN;
          start_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_RUN: if (hold) state_d = SEQ_HOLD;
      default: state_d = SEQ_HOLD;
    endcase
  end

  always_ff @(posedge clk_osc or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      state_q <= SEQ_HOLD;
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      if (state_q != SEQ_RUN) cnt_q <= cnt_d;
    end
  end

  assign init_rst  = (state_q != SEQ_RUN);
  assign cpu_start = start_q;
endmodule

// File: rtl/init_reset_seq_chk.sv
module init_reset_seq_chk #(
  parameter int OSC_WAIT = 8192
) (
  input logic clk_osc,
  input logic rst_pin_n,
  input logic init_rst,
  input logic cpu_start
);
  localparam int HW = $clog2(OSC_WAIT + 1);
  localparam logic [HW-1:0] HI_FULL = HW'(OSC_WAIT);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_osc or negedge rst_pin_n) begin
    if (!rst_pin_n)         hi_cnt <= '0;
    else if (!init_rst)     hi_cnt <= '0;
    else if (hi_cnt != HI_FULL) hi_cnt <= hi_cnt + 1'b1;
  end

  // R1
  pin_holds_reset_chk: assert property (@(posedge clk_osc)
    !rst_pin_n |-> (init_rst && !cpu_start));

  // R2
  min_wait_before_start_chk: assert property (@(posedge clk_osc) disable iff (!rst_pin_n)
    cpu_start |-> (hi_cnt == HI_FULL));

  // R12
  start_drops_reset_chk: assert property (@(posedge clk_osc) disable iff (!rst_pin_n)
    cpu_start |-> (!init_rst && $past(init_rst)));

  // R12
  start_single_cycle_chk: assert property (@(posedge clk_osc) disable iff (!rst_pin_n)
    cpu_start |=> !cpu_start);

  // R12
  release_only_on_start_chk: assert property (@(posedge clk_osc) disable iff (!rst_pin_n)
    $fell(init_rst) |-> cpu_start);
endmodule

bind init_reset_seq init_reset_seq_chk #(.OSC_WAIT(OSC_WAIT)) u_chk (
  .clk_osc(clk_osc), .rst_pin_n(rst_pin_n), .init_rst(init_rst), .cpu_start(cpu_start));

// File: tb/init_reset_seq_bench.sv
`timescale 1ns/1ps
module init_reset_seq_bench;
  localparam int NPIN = 4;
  localparam int OSC  = 8192;
  localparam int SVDW = 248;
  localparam int DIV  = 4096;
  localparam int PLEN = 64;

  logic            clk = 1'b0;
  logic            rst_pin_n;
  logic [NPIN-1:0] port_pins, port_mask;
  logic            sleep_mode, svd_enable, svd_strobe;
  logic [1:0]      svd_code;
  logic            init_rst, cpu_start;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { int cyc; string req; } exp_t;
  exp_t exp_q[$];

  init_reset_seq #(.NPIN(NPIN), .OSC_WAIT(OSC), .SVD_WAIT(SVDW), .DROP_RUN(4),
                   .TICK_DIV(DIV), .PULSE_LEN(PLEN)) u_init_reset_seq (
    .clk_osc(clk), .rst_pin_n(rst_pin_n), .port_pins(port_pins), .port_mask(port_mask),
    .sleep_mode(sleep_mode), .svd_enable(svd_enable), .svd_code(svd_code),
    .svd_strobe(svd_strobe), .init_rst(init_rst), .cpu_start(cpu_start));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Monitor: each start strobe is matched against the next expected item.
  always @(negedge clk) begin
    if (rst_pin_n === 1'b1 && cpu_start === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected start", cyc, -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(cyc == e.cyc, e.req, cyc, e.cyc);
      end
    end
  end

  task automatic push_start(input int at, input string req);
    exp_t e;
    e.cyc = at;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_start(input int limit, input string req);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (cpu_start !== 1'b1 && n < limit);
    check(cpu_start === 1'b1, req, cpu_start, 1);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sample(input logic [1:0] c);
    @(negedge clk);
    svd_code   = c;
    svd_strobe = 1'b1;
    @(negedge clk);
    svd_strobe = 1'b0;
  endtask

  task automatic pin_reset(input bit svd_on);
    @(posedge clk);
    #3 rst_pin_n = 1'b0;
    #1 check(init_rst === 1'b1, "R1 async assert", init_rst, 1);
    svd_enable = svd_on;
    port_pins  = '1;
    sleep_mode = 1'b0;
    idle(3);
    check(init_rst === 1'b1 && cpu_start === 1'b0, "R1 held", init_rst, 1);
  endtask

  initial begin
    #(190000 * 10);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    rst_pin_n  = 1'b0;
    port_pins  = '1;
    port_mask  = 4'b0111;
    sleep_mode = 1'b0;
    svd_enable = 1'b0;
    svd_code   = 2'd3;
    svd_strobe = 1'b0;
    idle(3);
    check(init_rst === 1'b1 && cpu_start === 1'b0, "R1 reset state", init_rst, 1);

    // R2: plain start-up from the pin
    @(negedge clk);
    rst_pin_n = 1'b1;
    push_start(cyc + 3 + OSC, "R2 start cycle");
    wait_start(OSC + 20, "R2 start seen");
    idle(5);
    check(init_rst === 1'b0, "R2 reset stays low", init_rst, 0);

    // R4 / R3: voltage source enabled at power-up
    pin_reset(1'b1);
    @(negedge clk);
    rst_pin_n = 1'b1;
    idle(20);
    check(init_rst === 1'b1, "R4 held without good sample", init_rst, 1);
    sample(2'd1);
    idle(10);
    check(init_rst === 1'b1, "R4 code 1 keeps hold", init_rst, 1);
    @(negedge clk);
    svd_code   = 2'd2;
    svd_strobe = 1'b1;
    push_start(cyc + 4 + OSC + SVDW, "R3 extended wait");
    @(negedge clk);
    svd_strobe = 1'b0;
    wait_start(OSC + SVDW + 20, "R3 start seen");

    // R5: run of drop samples broken by a mid sample
    sample(2'd0); sample(2'd0); sample(2'd0);
    sample(2'd1);
    sample(2'd0); sample(2'd0); sample(2'd0);
    idle(10);
    check(init_rst === 1'b0, "R5 three drops ignored", init_rst, 0);
    sample(2'd0);
    idle(6);
    check(init_rst === 1'b1, "R5 fourth drop asserts", init_rst, 1);
    sample(2'd1);
    idle(10);
    check(init_rst === 1'b1, "R6 mid code keeps hold", init_rst, 1);
    @(negedge clk);
    svd_code   = 2'd3;
    svd_strobe = 1'b1;
    push_start(cyc + 4 + OSC + SVDW, "R6 release timing");
    @(negedge clk);
    svd_strobe = 1'b0;
    wait_start(OSC + SVDW + 20, "R6 start seen");

    // R8 + R6: sleep port hold overlapping a voltage fault
    sleep_mode = 1'b1;
    port_pins  = 4'b1000;
    idle(5);
    check(init_rst === 1'b1, "R8 sleep hold", init_rst, 1);
    sample(2'd0); sample(2'd0); sample(2'd0); sample(2'd0);
    port_pins = 4'b1111;
    idle(20);
    check(init_rst === 1'b1, "R8 overlap still held by voltage fault", init_rst, 1);
    @(negedge clk);
    svd_code   = 2'd2;
    svd_strobe = 1'b1;
    push_start(cyc + 4 + OSC + SVDW, "R8 overlap release");
    @(negedge clk);
    svd_strobe = 1'b0;
    wait_start(OSC + SVDW + 20, "R8 overlap start seen");

    // Port tests with the voltage source off
    pin_reset(1'b0);
    @(negedge clk);
    rst_pin_n = 1'b1;
    push_start(cyc + 3 + OSC, "R2 second start");
    wait_start(OSC + 20, "R2 second start seen");

    // R7: unmasked pin low, masked pin 0 high -> no trigger
    sleep_mode = 1'b1;
    @(negedge clk);
    port_pins = 4'b0001;
    idle(10);
    check(init_rst === 1'b0, "R7 partial group ignored", init_rst, 0);

    // R8: sleep trigger timing (unmasked pin 3 high is ignored, R7)
    @(negedge clk);
    port_pins = 4'b1000;
    idle(2);
    check(init_rst === 1'b0, "R8 not before third edge", init_rst, 0);
    idle(1);
    check(init_rst === 1'b1, "R8 third edge R7 masked only", init_rst, 1);
    idle(50);
    check(init_rst === 1'b1, "R8 holds while low", init_rst, 1);
    @(negedge clk);
    port_pins = 4'b1111;
    push_start(cyc + 3 + OSC, "R8 start after release");
    wait_start(OSC + 20, "R8 start seen");

    // R9 / R10: awake qualification and pulse
    sleep_mode = 1'b0;
    begin
      int k = 0;
      @(negedge clk);
      port_pins = 4'b0000;
      do begin
        @(negedge clk);
        k++;
      end while (init_rst !== 1'b1 && k < 2 * DIV + 20);
      check(k >= DIV + 4 && k <= 2 * DIV + 3, "R9 qualification delay", k, DIV + 4);
      push_start(cyc + PLEN + OSC, "R10 pulse start with pins low");
    end
    wait_start(PLEN + OSC + 20, "R10 start seen");

    // R11: no retrigger while low
    idle(2 * DIV + 100);
    check(init_rst === 1'b0, "R11 no retrigger", init_rst, 0);

    // R11: re-arm after a selected pin goes high
    @(negedge clk);
    port_pins = 4'b1111;
    idle(5);
    port_pins = 4'b0000;
    begin
      int k = 0;
      do begin
        @(negedge clk);
        k++;
      end while (init_rst !== 1'b1 && k < 2 * DIV + 20);
      check(k >= DIV + 4 && k <= 2 * DIV + 3, "R11 re-armed trigger", k, DIV + 4);
      push_start(cyc + PLEN + OSC, "R11 start after re-arm");
    end
    wait_start(PLEN + OSC + 20, "R11 start seen");

    idle(10);
    check(exp_q.size() == 0, "R12 all starts matched", exp_q.size(), 0);
    finish_run();
  end
endmodule